// File: doc/BRIEF.md
# HDLC Transmit Framer with Pad Preamble

This block turns a stream of payload bytes into a bit-serial HDLC line. It opens each frame with a 7Eh flag and sends the payload bytes LSB first. By default it appends a 16-bit frame check sequence, then closes the frame with another flag. Zero-bit insertion keeps payload and FCS bits from ever forming a flag. One line bit goes out for each pulse of the bit-enable strobe. The line can rest between frames either as a continuous run of flags or as a steady mark (logic 1).

A remote receiver may need a known bit pattern to lock its clock-recovery loop after a period of mark idle. For that case the framer can send one to four pad bytes ahead of the opening flag. Each pad byte is either 00h or AAh. A byte-wide option register selects all of the following:
- whether padding is enabled;
- the pad byte value;
- the pad count;
- the CRC preset;
- whether the FCS is sent at all;
- the idle style.

Payload arrives over a valid/ready byte interface, and an end-of-frame marker is carried with the last byte.

Top module: `hdlc_pad_tx`

## Requirements
- R1: After reset the option register reads 00h and `txBit` is 1 until the first bit strobe.
- R2: The option register is written and read as one byte. Its fields are:
  - bit 7: pad enable;
  - bit 6: pad value, 1 = AAh and 0 = 00h;
  - bit 5: CRC preset, 0 = all ones and 1 = all zeros;
  - bit 4: FCS disable;
  - bit 3: idle style, 1 = mark and 0 = flags;
  - bits 2:0: pad count.
- R3: With bit 3 clear and no frame pending, the line carries back-to-back 7Eh flags, LSB first.
- R4: With bit 3 set and no frame pending, the line stays at 1.
- R5: When a frame starts out of mark idle with bit 7 set and a pad count code of 1 to 4, exactly that many pad bytes of the selected value go out, unstuffed and LSB first, just before the opening flag.
- R6: No pad byte is sent in any of these cases:
  - the pad count code is 000 or 101 to 111;
  - bit 7 is clear;
  - the frame starts out of flag idle.
- R7: After every five consecutive 1s in payload or FCS bits, a 0 is inserted, including just before the closing flag. Flags and pad bytes are never stuffed.
- R8: The FCS uses the polynomial x^16+x^12+x^5+1, processed LSB first over the payload bits, and is sent low bit first. With the all-ones preset the register is complemented before sending; with the all-zeros preset it is sent as is.
- R9: With bit 4 set, the frame carries only the payload between its flags.
- R10: After the closing flag the line returns to the selected idle style. If the next frame's first byte is already valid, the closing flag also opens that frame, with no pads.
- R11: Accepted payload bytes appear on the line in acceptance order, each LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| optWrEn | input | 1 | Option register write strobe |
| optWrData | input | 8 | Option register write value |
| optRdData | output | 8 | Option register contents |
| bitEn | input | 1 | One line bit per cycle with this high |
| inData | input | 8 | Payload byte |
| inValid | input | 1 | Payload byte valid |
| inLast | input | 1 | Payload byte is the last of its frame |
| inReady | output | 1 | Payload byte taken at this edge |
| txBit | output | 1 | Serial line bit |

## Verification
The hardest situations to reach are those that depend on what the line was doing before a frame began:
- pads appear only when the last idle byte was a mark;
- the shared-flag path is taken only when the following frame is valid at the moment the closing flag is chosen.

The stimulus first lets the line run in the chosen idle style for several bytes, then raises valid. For back-to-back frames it presents the second frame's first byte as soon as the last byte of the first frame is taken. Payloads rich in runs of ones push stuffing across byte boundaries and into the FCS.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_OCTET = 8'h7E;
  localparam logic [BYTE_W-1:0] MARK_OCTET = 8'hFF;
  localparam logic [BYTE_W-1:0] PAD_ALT_OCTET = 8'hAA;
  localparam logic [BYTE_W-1:0] PAD_ZERO_OCTET = 8'h00;

  // What the datapath is currently shifting out
  typedef enum logic [2:0] {
    K_MARK, K_FLAG, K_PAD, K_DATA, K_FCS
  } itemKind_e;

  // Option byte, MSB first
  typedef struct packed {
    logic       padOn;
    logic       padAlt;
    logic       presetZero;
    logic       fcsOff;
    logic       idleMark;
    logic [2:0] padCount;
  } txOpt_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic              load;
    itemKind_e         kind;
    logic [BYTE_W-1:0] octet;
    logic              crcInit;
    logic              presetZero;
  } txStrobe_t;
endpackage

// File: rtl/hdlc_tx_optreg.sv
module hdlc_tx_optreg
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output txOpt_t            opt
);
  logic [BYTE_W-1:0] optQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) optQ <= '0;
    else if (wrEn) optQ <= wrData;
  end

  assign rdData = optQ;
  assign opt    = txOpt_t'(optQ);

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == $past(wrData)));
endmodule

// File: rtl/hdlc_tx_datapath.sv
module hdlc_tx_datapath
  import hdlc_tx_pkg::*;
#(
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter int STUFF_RUN = 5
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  txStrobe_t strobe,
  output logic      needItem,
  output logic      txBit
);
  localparam int CNT_W  = $clog2(CRC_W);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam logic [CNT_W-1:0]  BYTE_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0]  FCS_LAST  = CNT_W'(CRC_W - 1);
  localparam logic [ONES_W-1:0] RUN_MAX   = ONES_W'(STUFF_RUN);

  logic [BYTE_W-1:0] shReg;
  logic [CRC_W-1:0]  crcReg;
  logic [CRC_W-1:0]  crcStep;
  itemKind_e         curKind;
  logic [CNT_W-1:0]  bitCnt;
  logic [ONES_W-1:0] onesCnt;
  logic              fcsInv;
  logic              txBitQ;
  logic              stuffNow;
  logic              stuffable;
  logic              itemLast;
  logic              curBit;
  logic              fb;

  assign stuffNow  = (onesCnt == RUN_MAX);
  assign stuffable = (curKind == K_DATA) || (curKind == K_FCS);
  assign itemLast  = (curKind == K_FCS) ? (bitCnt == FCS_LAST) : (bitCnt == BYTE_LAST);
  assign curBit    = (curKind == K_FCS) ? (crcReg[0] ^ fcsInv) : shReg[0];
  assign needItem  = bitEn && !stuffNow && itemLast;

  always_comb begin
    fb      = crcReg[0] ^ shReg[0];
    crcStep = (crcReg >> 1) ^ (fb ? CRC_POLY : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= MARK_OCTET;
      curKind <= K_MARK;
      bitCnt  <= BYTE_LAST;
      onesCnt <= '0;
      crcReg  <= '1;
      fcsInv  <= 1'b1;
      txBitQ  <= 1'b1;
    end else if (bitEn) begin
      if (stuffNow) begin
        txBitQ  <= 1'b0;
        onesCnt <= '0;
      end else begin
        txBitQ <= curBit;
        if (stuffable) onesCnt <= curBit ? onesCnt + ONES_W'(1) : '0;
        else onesCnt <= '0;
        if (curKind == K_DATA) crcReg <= crcStep;
        else if (curKind == K_FCS) crcReg <= crcReg >> 1;
        if (itemLast) begin
          if (strobe.load) begin
            shReg   <= strobe.octet;
            curKind <= strobe.kind;
            bitCnt  <= '0;
            if (strobe.crcInit) begin
              crcReg <= strobe.presetZero ? '0 : '1;
              fcsInv <= !strobe.presetZero;
            end
          end
        end else begin
          shReg  <= shReg >> 1;
          bitCnt <= bitCnt + CNT_W'(1);
        end
      end
    end
  end

  assign txBit = txBitQ;

  p_stuff_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && stuffNow) |=> !txBit);
  p_ones_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    onesCnt <= RUN_MAX);
  p_mark_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !stuffNow && curKind == K_MARK) |=> txBit);
  p_need_loads_r11: assert property (@(posedge clk) disable iff (!rstN)
    needItem |-> strobe.load);
  p_load_only_on_need_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> needItem);
endmodule

// File: rtl/hdlc_tx_control.sv
module hdlc_tx_control
  import hdlc_tx_pkg::*;
#(
  parameter int MAX_PAD = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              needItem,
  input  txOpt_t            opt,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output txStrobe_t         strobe
);
  localparam int PC_W = $bits(opt.padCount);

  typedef enum logic [2:0] {
    C_IDLE, C_PAD, C_OPEN, C_DATA, C_FCS, C_CLOSE
  } ctlState_e;

  ctlState_e         state, stateNext;
  logic [PC_W-1:0]   padLeft, padLeftNext;
  logic              lastTaken, lastTakenNext;
  logic              wasMark;
  logic              padCountOk;
  logic [BYTE_W-1:0] padOctet;

  assign padCountOk = (opt.padCount != '0) && (opt.padCount <= PC_W'(MAX_PAD));
  assign padOctet   = opt.padAlt ? PAD_ALT_OCTET : PAD_ZERO_OCTET;

  always_comb begin
    strobe            = '0;
    strobe.kind       = K_MARK;
    strobe.octet      = MARK_OCTET;
    strobe.presetZero = opt.presetZero;
    strobe.load       = needItem;
    stateNext         = state;
    padLeftNext       = padLeft;
    lastTakenNext     = lastTaken;
    inReady           = 1'b0;
    if (needItem) begin
      unique case (state)
        C_IDLE: begin
          if (inValid && wasMark && opt.padOn && padCountOk) begin
            strobe.kind  = K_PAD;
            strobe.octet = padOctet;
            padLeftNext  = opt.padCount - PC_W'(1);
            stateNext    = C_PAD;
          end else if (inValid) begin
            strobe.kind  = K_FLAG;
            strobe.octet = FLAG_OCTET;
            stateNext    = C_OPEN;
          end else if (opt.idleMark) begin
            strobe.kind  = K_MARK;
            strobe.octet = MARK_OCTET;
          end else begin
            strobe.kind  = K_FLAG;
            strobe.octet = FLAG_OCTET;
          end
        end
        C_PAD: begin
          if (padLeft != '0) begin
            strobe.kind  = K_PAD;
            strobe.octet = padOctet;
            padLeftNext  = padLeft - PC_W'(1);
          end else begin
            strobe.kind  = K_FLAG;
            strobe.octet = FLAG_OCTET;
            stateNext    = C_OPEN;
          end
        end
        C_OPEN, C_CLOSE: begin
          if (inValid) begin
            strobe.kind    = K_DATA;
            strobe.octet   = inData;
            strobe.crcInit = 1'b1;
            inReady        = 1'b1;
            lastTakenNext  = inLast;
            stateNext      = C_DATA;
          end else if (state == C_OPEN || !opt.idleMark) begin
            strobe.kind  = K_FLAG;
            strobe.octet = FLAG_OCTET;
            stateNext    = (state == C_OPEN) ? C_OPEN : C_IDLE;
          end else begin
            strobe.kind  = K_MARK;
            strobe.octet = MARK_OCTET;
            stateNext    = C_IDLE;
          end
        end
        C_DATA: begin
          if (!lastTaken && inValid) begin
            strobe.kind   = K_DATA;
            strobe.octet  = inData;
            inReady       = 1'b1;
            lastTakenNext = inLast;
          end else if (!opt.fcsOff) begin
            strobe.kind = K_FCS;
            stateNext   = C_FCS;
          end else begin
            strobe.kind  = K_FLAG;
            strobe.octet = FLAG_OCTET;
            stateNext    = C_CLOSE;
          end
        end
        default: begin
          strobe.kind  = K_FLAG;
          strobe.octet = FLAG_OCTET;
          stateNext    = C_CLOSE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= C_IDLE;
      padLeft   <= '0;
      lastTaken <= 1'b0;
      wasMark   <= 1'b0;
    end else begin
      state     <= stateNext;
      padLeft   <= padLeftNext;
      lastTaken <= lastTakenNext;
      if (needItem) wasMark <= (strobe.kind == K_MARK);
    end
  end

  p_pad_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == K_PAD && state == C_IDLE) |-> (opt.padOn && padCountOk));
  p_pad_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == C_PAD) |-> (padLeft < PC_W'(MAX_PAD)));
  p_no_pad_from_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (needItem && state == C_IDLE && !wasMark) |-> (strobe.kind != K_PAD));
  p_share_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == C_CLOSE && needItem && inValid) |=> (state == C_DATA));
endmodule

// File: rtl/hdlc_pad_tx.sv
module hdlc_pad_tx
  import hdlc_tx_pkg::*;
#(
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
  parameter int STUFF_RUN = 5,
  parameter int MAX_PAD = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       optWrEn,
  input  logic [7:0] optWrData,
  output logic [7:0] optRdData,
  input  logic       bitEn,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       inLast,
  output logic       inReady,
  output logic       txBit
);
  txOpt_t    opt;
  txStrobe_t strobe;
  logic      needItem;

  hdlc_tx_optreg u_opt (
    .clk(clk), .rstN(rstN), .wrEn(optWrEn), .wrData(optWrData),
    .rdData(optRdData), .opt(opt)
  );

  hdlc_tx_control #(.MAX_PAD(MAX_PAD)) u_ctl (
    .clk(clk), .rstN(rstN), .needItem(needItem), .opt(opt),
    .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .strobe(strobe)
  );

  hdlc_tx_datapath #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY), .STUFF_RUN(STUFF_RUN)) u_dp (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .strobe(strobe),
    .needItem(needItem), .txBit(txBit)
  );
endmodule

// File: tb/hdlc_pad_tx_test.sv
module hdlc_pad_tx_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic optWrEn;
  logic [7:0] optWrData;
  logic [7:0] optRdData;
  logic bitEn;
  logic [7:0] inData;
  logic inValid;
  logic inLast;
  logic inReady;
  logic txBit;

  int checks = 0;
  int fails = 0;
  bit run = 0;
  bit capOn = 0;
  bit finished = 0;
  bit capQ[$];
  bit expQ[$];
  int stuffOnes;
  logic [7:0] mem [0:31];

  hdlc_pad_tx uut (
    .clk(clk), .rstN(rstN), .optWrEn(optWrEn), .optWrData(optWrData),
    .optRdData(optRdData), .bitEn(bitEn), .inData(inData), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .txBit(txBit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: record each line bit after the edge that produced it, then toggle the strobe
  always @(negedge clk) begin
    if (run && capOn && bitEn) capQ.push_back(txBit);
    if (run) bitEn = ~bitEn;
    else bitEn = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard builders
  task automatic pushRaw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) expQ.push_back(b[i]);
  endtask

  task automatic pushStuffed(input bit b);
    expQ.push_back(b);
    if (b) stuffOnes++; else stuffOnes = 0;
    if (stuffOnes == 5) begin
      expQ.push_back(1'b0);
      stuffOnes = 0;
    end
  endtask

  task automatic pushFrame(input int first, input int n, input bit presetZero, input bit fcsOff);
    logic [15:0] crc;
    logic [15:0] fcs;
    bit fbit;
    crc = presetZero ? 16'h0000 : 16'hFFFF;
    stuffOnes = 0;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        fbit = crc[0] ^ mem[first+k][i];
        crc = crc >> 1;
        if (fbit) crc = crc ^ 16'h8408;
        pushStuffed(mem[first+k][i]);
      end
    end
    if (!fcsOff) begin
      fcs = presetZero ? crc : ~crc;
      for (int i = 0; i < 16; i++) pushStuffed(fcs[i]);
    end
  endtask

  task automatic setOpt(input logic [7:0] v);
    @(posedge clk); #1;
    optWrEn = 1'b1;
    optWrData = v;
    @(posedge clk); #1;
    optWrEn = 1'b0;
    chk(optRdData == v, "R2", "option readback", optRdData, v);
  endtask

  // Driver: one byte per handshake
  task automatic sendBytes(input int first, input int n);
    @(posedge clk); #1;
    for (int k = 0; k < n; k++) begin
      inData = mem[first+k];
      inLast = (k == n-1);
      inValid = 1'b1;
      forever begin
        @(negedge clk); #1;
        if (inReady) break;
      end
      @(posedge clk); #1;
    end
    inValid = 1'b0;
    inLast = 1'b0;
  endtask

  task automatic waitBits(input int k);
    while (capQ.size() < k) @(negedge clk);
  endtask

  function automatic logic [7:0] capByte(input int at);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[i] = capQ[at+i];
    return b;
  endfunction

  task automatic analyze(input string req, input bit markMode);
    int s;
    int mism;
    s = -1;
    mism = -1;
    if (markMode) begin
      for (int i = 0; i < capQ.size(); i++) if (capQ[i] == 1'b0) begin s = i; break; end
    end else begin
      for (int i = 0; i + 16 <= capQ.size(); i++)
        if (capByte(i) == 8'h7E && capByte(i+8) != 8'h7E) begin s = i; break; end
    end
    chk(s >= 0, req, "frame start located", s, 0);
    if (s < 0) return;
    for (int j = 0; j < expQ.size(); j++)
      if (capQ[s+j] != expQ[j]) begin mism = j; break; end
    if (mism >= 0)
      chk(1'b0, req, $sformatf("line bit %0d of frame", mism), capQ[s+mism], expQ[mism]);
    else
      chk(1'b1, req, "frame bits", 0, 0);
    chk(capByte(s + expQ.size()) == (markMode ? 8'hFF : 8'h7E), "R10", "idle after closing flag",
        capByte(s + expQ.size()), markMode ? 8'hFF : 8'h7E);
  endtask

  task automatic runFrame(input string req, input logic [7:0] opt, input int padN,
                          input logic [7:0] padPat, input int f1, input int n1,
                          input int f2, input int n2);
    setOpt(opt);
    capOn = 0;
    repeat (60) @(negedge clk);
    capQ.delete();
    expQ.delete();
    for (int p = 0; p < padN; p++) pushRaw(padPat);
    pushRaw(8'h7E);
    pushFrame(f1, n1, opt[5], opt[4]);
    pushRaw(8'h7E);
    if (n2 > 0) begin
      pushFrame(f2, n2, opt[5], opt[4]);
      pushRaw(8'h7E);
    end
    capOn = 1;
    sendBytes(f1, n1);
    if (n2 > 0) sendBytes(f2, n2);
    waitBits(expQ.size() + 80);
    capOn = 0;
    analyze(req, opt[3]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mem[0] = 8'hFF; mem[1] = 8'h7E; mem[2] = 8'h3C; mem[3] = 8'hF8; mem[4] = 8'h1F;
    mem[5] = 8'h12; mem[6] = 8'h34; mem[7] = 8'hAB;
    mem[8] = 8'h55;
    mem[9] = 8'h81; mem[10] = 8'h42;
    mem[11] = 8'h0F;
    mem[12] = 8'hE7; mem[13] = 8'h00;
    mem[14] = 8'hC3; mem[15] = 8'h3E;
    mem[16] = 8'hFC; mem[17] = 8'hFF;
    mem[18] = 8'h01; mem[19] = 8'hBE; mem[20] = 8'hFD;
    mem[21] = 8'h77; mem[22] = 8'hF0;
    for (int i = 23; i < 32; i++) mem[i] = 8'h00;

    rstN = 1'b0; optWrEn = 1'b0; optWrData = 8'h00;
    inData = 8'h00; inValid = 1'b0; inLast = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(optRdData == 8'h00, "R1", "option after reset", optRdData, 0);
    chk(txBit == 1'b1, "R1", "line after reset", txBit, 1);
    run = 1;

    // R3: flag idle
    setOpt(8'h00);
    repeat (40) @(negedge clk);
    capQ.delete(); capOn = 1; waitBits(48); capOn = 0;
    begin
      int f;
      f = -1;
      for (int i = 0; i < 8; i++) if (capByte(i) == 8'h7E) begin f = i; break; end
      chk(f >= 0, "R3", "flag found in idle", f, 0);
      if (f >= 0)
        for (int k = 1; k < 4; k++)
          chk(capByte(f + 8*k) == 8'h7E, "R3", "consecutive idle flag", capByte(f + 8*k), 8'h7E);
    end

    // R4: mark idle
    setOpt(8'h08);
    repeat (40) @(negedge clk);
    capQ.delete(); capOn = 1; waitBits(40); capOn = 0;
    begin
      int zeros;
      zeros = 0;
      for (int i = 0; i < 40; i++) if (!capQ[i]) zeros++;
      chk(zeros == 0, "R4", "zero bits during mark idle", zeros, 0);
    end

    runFrame("R5 R7 R8 R11 three AAh pads ones preset", 8'hCB, 3, 8'hAA, 0, 5, 0, 0);
    runFrame("R5 R8 one 00h pad zeros preset", 8'hA9, 1, 8'h00, 5, 3, 0, 0);
    runFrame("R5 four 00h pads", 8'h8C, 4, 8'h00, 8, 1, 0, 0);
    runFrame("R6 reserved count 000", 8'hC8, 0, 8'h00, 9, 2, 0, 0);
    runFrame("R6 reserved count 110", 8'hCE, 0, 8'h00, 11, 1, 0, 0);
    runFrame("R6 padding disabled", 8'h4A, 0, 8'h00, 12, 2, 0, 0);
    runFrame("R6 R3 start from flag idle", 8'hC2, 0, 8'h00, 14, 2, 0, 0);
    runFrame("R9 R7 FCS disabled", 8'h18, 0, 8'h00, 16, 2, 0, 0);
    runFrame("R10 R5 back-to-back shared flag", 8'hCA, 2, 8'hAA, 18, 3, 21, 2);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule